// File: doc/BRIEF.md
# Speculative-Bit Montgomery Processing Element

This block is one processing element of a parallelized radix-2 scalable Montgomery multiplier. In one pass it applies a single multiplier bit to a stream of W-bit words, least significant word first. Each word beat carries one word of the running partial sum Z, one word of the multiplicand Y and one word of the pre-scaled modulus Mh. Mh is (M+1)/2 for an odd modulus M. Because Mh replaces M, the reduction and the multiplication are added in one step. On every word the element adds Z shifted right by one bit, Mh gated by the reduction bit, and Y gated by the multiplier bit.

Word j of the shifted sum needs bit 0 of word j+1, which arrives one beat later. The element therefore forms two candidate results for word j when word j arrives: one with that bit taken as 1 and one with it taken as 0. When word j+1 arrives it keeps the matching candidate and its carry. A chain of such elements then advances by one word per cycle instead of two. A parameter selects the dual-candidate datapath or a single adder that completes the sum after the bit is known. Both give the same behaviour at the ports.

Top module: `mont_spec_pe`

## Requirements
- R1: While reset is low and after its release, out_valid, out_first and out_last are 0 until the first beat arrives.
- R2: For a pass of k words (in_first on word 0, in_last on word k-1, words little-endian), the output words form ((Z >> 1) + q·Mh + x·Y) mod 2^(k·W). Here q is bit 0 of Z and x is the multiplier bit.
- R3: The reduction bit q and the multiplier bit x are taken only on the in_first beat and held for the whole pass. Bit 0 of later Z words and x_bit on later beats do not change them.
- R4: The word carry (0 to 2) is cleared at each in_first beat, so the result of a pass does not depend on the pass before it.
- R5: The top bit of output word j is bit 0 of input Z word j+1. The last word of a pass shifts in 0, never a bit of the following pass.
- R6: Output word j is presented one cycle after the beat that carries word j+1. The last word is presented one cycle after that. With back-to-back beats, every word appears two cycles after its own beat.
- R7: out_first is 1 exactly on output word 0 and out_last exactly on the last output word of a pass. A one-word pass sets both on one output.
- R8: A cycle with in_valid low changes no state and causes no output word, whatever the data inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A word beat is present |
| in_first | input | 1 | Beat carries word 0 of a pass |
| in_last | input | 1 | Beat carries the last word of a pass |
| x_bit | input | 1 | Multiplier bit, sampled on the first beat |
| y_word | input | W | Multiplicand word |
| mh_word | input | W | Pre-scaled modulus word |
| z_word | input | W | Incoming partial-sum word |
| out_valid | output | 1 | An output word is present |
| out_first | output | 1 | Output word is word 0 of a pass |
| out_last | output | 1 | Output word is the last of a pass |
| out_word | output | W | New partial-sum word |

## Verification
The checker assumes that the cycle right after an in_last beat never carries a non-first beat. That slot is where the held top word leaves, and a beat placed there would collide with it. The stimulus always follows a last beat with either an idle cycle or the in_first beat of the next pass. The stimulus also keeps the data lines random while in_valid is low, and drives random x_bit values on non-first beats. It runs passes of one to five words back to back, separated by gaps, so the carry clear and the last-word shift are exercised across pass edges.

// File: rtl/mspe_pkg.sv
package mspe_pkg;
   // A word sum of three W-bit terms plus a carry can reach 3*2^W - 1,
   // so the carry between words needs two bits.
   localparam int CARRY_W = 2;
   typedef enum logic {PICK_EVEN = 1'b0, PICK_ODD = 1'b1} pick_t;
endpackage

// File: rtl/mspe_term_mux.sv
module mspe_term_mux #(
   parameter int W = 16
) (
   input  logic         en,
   input  logic [W-1:0] word,
   output logic [W-1:0] gated
);
   always_comb gated = en ? word : '0;
endmodule

// File: rtl/mspe_common_sum.sv
module mspe_common_sum #(
   parameter int W = 16
) (
   input  logic [W-2:0]                 zhi,
   input  logic [W-1:0]                 ta,
   input  logic [W-1:0]                 tb,
   input  logic [mspe_pkg::CARRY_W-1:0] cin,
   output logic [W+1:0]                 sum
);
   // shared part of both candidates: shifted Z without its top bit
   always_comb
      sum = {3'b000, zhi} + {2'b00, ta} + {2'b00, tb} + {{W{1'b0}}, cin};
endmodule

// File: rtl/mont_spec_pe.sv
module mont_spec_pe #(
   parameter int W         = 16,
   parameter bit SPECULATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic         in_first,
   input  logic         in_last,
   input  logic         x_bit,
   input  logic [W-1:0] y_word,
   input  logic [W-1:0] mh_word,
   input  logic [W-1:0] z_word,
   output logic         out_valid,
   output logic         out_first,
   output logic         out_last,
   output logic [W-1:0] out_word
);
   import mspe_pkg::*;

   localparam int            SW  = W + CARRY_W;
   localparam logic [SW-1:0] TOP = SW'(1) << (W - 1);

   if (W < 2) begin : g_bad_width
      $error("mont_spec_pe: W must be at least 2");
   end

   logic   red_q, x_q, pend0_q, flush_q;
   logic   red_cur, x_cur, resolve;
   pick_t  pick;
   logic [W-1:0] ym, mm, res_word;

   assign red_cur = in_first ? z_word[0] : red_q;
   assign x_cur   = in_first ? x_bit     : x_q;
   assign resolve = in_valid & ~in_first;
   // the held top word of a pass always takes a shifted-in 0
   assign pick    = (flush_q || !z_word[0]) ? PICK_EVEN : PICK_ODD;

   mspe_term_mux #(.W(W)) u_ygate (.en(x_cur),   .word(y_word),  .gated(ym));
   mspe_term_mux #(.W(W)) u_mgate (.en(red_cur), .word(mh_word), .gated(mm));

   if (SPECULATE) begin : g_dual
      logic [W-1:0]       so_q, se_q;
      logic [CARRY_W-1:0] co_q, ce_q, cin;
      logic [SW-1:0]      common, odd_s;

      always_comb begin
         if (in_first)             cin = '0;
         else if (pick == PICK_ODD) cin = co_q;
         else                      cin = ce_q;
      end

      mspe_common_sum #(.W(W)) u_sum (
         .zhi(z_word[W-1:1]), .ta(ym), .tb(mm), .cin(cin), .sum(common));

      assign odd_s    = common + TOP;
      assign res_word = (pick == PICK_ODD) ? so_q : se_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            so_q <= '0;
            se_q <= '0;
            co_q <= '0;
            ce_q <= '0;
         end else if (in_valid) begin
            so_q <= odd_s[W-1:0];
            co_q <= odd_s[SW-1:W];
            se_q <= common[W-1:0];
            ce_q <= common[SW-1:W];
         end
      end
   end else begin : g_late
      logic [SW-1:0]      p_q, partial, full;
      logic [CARRY_W-1:0] c_q;

      mspe_common_sum #(.W(W)) u_sum (
         .zhi(z_word[W-1:1]), .ta(ym), .tb(mm), .cin('0), .sum(partial));

      assign full     = p_q + ((pick == PICK_ODD) ? TOP : '0) + {{W{1'b0}}, c_q};
      assign res_word = full[W-1:0];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            p_q <= '0;
            c_q <= '0;
         end else if (in_valid) begin
            p_q <= partial;
            c_q <= in_first ? '0 : full[SW-1:W];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         red_q     <= 1'b0;
         x_q       <= 1'b0;
         pend0_q   <= 1'b0;
         flush_q   <= 1'b0;
         out_valid <= 1'b0;
         out_first <= 1'b0;
         out_last  <= 1'b0;
         out_word  <= '0;
      end else begin
         out_valid <= resolve | flush_q;
         out_first <= (resolve | flush_q) & pend0_q;
         out_last  <= flush_q;
         flush_q   <= in_valid & in_last;
         if (resolve | flush_q) out_word <= res_word;
         if (in_valid) pend0_q <= in_first;
         if (in_valid && in_first) begin
            red_q <= z_word[0];
            x_q   <= x_bit;
         end
      end
   end
endmodule

// File: rtl/mspe_checker.sv
module mspe_checker (
   input logic clk,
   input logic rst_n,
   input logic in_valid,
   input logic in_first,
   input logic in_last,
   input logic out_valid,
   input logic out_first,
   input logic out_last
);
   // R1: outputs quiet while reset is held
   always @(posedge clk)
      if (!rst_n) assert_reset_quiet_R1: assert (!out_valid && !out_first && !out_last);

   // input rule: the slot after a last beat is free of non-first beats (R6)
   assert_slot_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_last) |=> !(in_valid && !in_first));

   assert_resolve_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_first) |=> out_valid);

   assert_top_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_last) |-> ##2 (out_valid && out_last));

   assert_no_stray_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ($past(in_valid && !in_first) || $past(in_valid && in_last, 2)));

   assert_flags_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_first || out_last) |-> out_valid);

   assert_last_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> $past(in_valid && in_last, 2));
endmodule

bind mont_spec_pe mspe_checker u_mspe_checker (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
   .in_last(in_last), .out_valid(out_valid), .out_first(out_first),
   .out_last(out_last));

// File: tb/test_mont_spec_pe.sv
`timescale 1ns/1ps
module test_mont_spec_pe;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0, x_bit = 1'b0;
   logic [W-1:0] y_word = '0, mh_word = '0, z_word = '0;
   logic         out_valid, out_first, out_last;
   logic [W-1:0] out_word;

   int checks = 0, failures = 0, cyc = 0, stray = 0;

   typedef struct {
      logic [W-1:0] word;
      bit           f;
      bit           l;
      int           due;
      string        tag;
   } item_t;
   item_t sb[$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   mont_spec_pe #(.W(W)) i_mont_spec_pe (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
      .in_last(in_last), .x_bit(x_bit), .y_word(y_word), .mh_word(mh_word),
      .z_word(z_word), .out_valid(out_valid), .out_first(out_first),
      .out_last(out_last), .out_word(out_word));

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // monitor: pops the scoreboard as words leave the design
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (sb.size() == 0) begin
            stray++;
            check(1'b0, "R8", "unexpected word", out_word, 0);
         end else begin
            item_t e;
            e = sb.pop_front();
            check(out_word == e.word, e.tag, "word (R2)", out_word, e.word);
            check(out_first == e.f && out_last == e.l, e.tag, "flags (R7)",
                  {out_first, out_last}, {e.f, e.l});
            check(cyc == e.due, e.tag, "timing (R6)", cyc, e.due);
         end
      end else if (rst_n && sb.size() != 0 && sb[0].due == cyc) begin
         check(1'b0, sb[0].tag, "missing word (R6)", 0, sb[0].word);
         void'(sb.pop_front());
      end
   end

   function automatic logic [63:0] ref_pass(input logic [63:0] z, y, mh,
                                            input bit xb, input int k);
      logic [63:0] s;
      s = (z >> 1) + (z[0] ? mh : 64'd0) + (xb ? y : 64'd0);
      return (k * W >= 64) ? s : (s & ((64'd1 << (k * W)) - 1));
   endfunction

   task automatic idle_junk(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_first = $urandom_range(0, 1);
         in_last  = $urandom_range(0, 1);
         x_bit    = $urandom_range(0, 1);
         y_word   = W'($urandom);
         mh_word  = W'($urandom);
         z_word   = W'($urandom);
      end
   endtask

   task automatic run_pass(input int k, input logic [63:0] z, y, mh,
                           input bit xb, input string tag);
      logic [63:0] r;
      r = ref_pass(z, y, mh, xb, k);
      for (int j = 0; j < k; j++) begin
         item_t e;
         @(negedge clk);
         in_valid = 1'b1;
         in_first = (j == 0);
         in_last  = (j == k - 1);
         x_bit    = (j == 0) ? xb : bit'($urandom_range(0, 1)); // R3 noise
         y_word   = y[j*W +: W];
         mh_word  = mh[j*W +: W];
         z_word   = z[j*W +: W];
         e.word = r[j*W +: W];
         e.f    = (j == 0);
         e.l    = (j == k - 1);
         e.due  = cyc + 2;
         e.tag  = tag;
         sb.push_back(e);
      end
   endtask

   function automatic logic [63:0] rnd(input int k);
      logic [63:0] v;
      v = {$urandom, $urandom};
      return v & ((64'd1 << (k * W)) - 1);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(!out_valid && !out_first && !out_last, "R1", "outputs in reset",
            {out_valid, out_first, out_last}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!out_valid && !out_first && !out_last, "R1", "outputs after reset",
            {out_valid, out_first, out_last}, 0);

      // R8: junk on data lines while in_valid is low
      idle_junk(10);
      check(stray == 0 && sb.size() == 0, "R8", "idle produced words", stray, 0);

      // R4: large operands leave carry 2, next pass starts clean
      run_pass(4, 64'hFFFF_FFFF, 64'hFFFF_FFFF, 64'hFFFF_FFFF, 1'b1, "R4");
      run_pass(4, 64'h0000_0102, 64'h0000_0001, 64'h0000_0003, 1'b0, "R4");
      idle_junk(3);

      // R3: word 0 even, later words odd; x noise on later beats
      run_pass(4, 64'h0101_0100, 64'hA5A5_A5A5, 64'h7777_7777, 1'b0, "R3");
      run_pass(4, 64'h8181_8180, 64'h1234_5678, 64'h7777_7777, 1'b1, "R3");
      idle_junk(2);

      // R5: odd top word, next pass word 0 odd, back to back
      run_pass(3, 64'h01_FF_FF, 64'h00_00_00, 64'h00_00_00, 1'b0, "R5");
      run_pass(2, 64'hFF_FF,    64'h00_00,    64'h00_00,    1'b0, "R5");
      idle_junk(2);

      // R7: one-word passes
      run_pass(1, 64'hFF, 64'hFF, 64'hFF, 1'b1, "R7");
      run_pass(1, 64'h03, 64'h10, 64'h81, 1'b0, "R7");
      idle_junk(3);

      // R2: random passes of mixed length and spacing
      for (int t = 0; t < 60; t++) begin
         int k;
         k = $urandom_range(1, 5);
         run_pass(k, rnd(k), rnd(k), rnd(k), bit'($urandom_range(0, 1)), "R2");
         if ($urandom_range(0, 2) != 0) idle_junk($urandom_range(1, 3));
      end
      idle_junk(6);
      check(sb.size() == 0, "R6", "words left undelivered", sb.size(), 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule